// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It runs two direction predictors side by side and uses a third table to decide, per branch, which of the two to trust. The first predictor is local: a per-PC history table records the last outcomes of the branches that map to each entry, and that history selects one of a set of shared 3-bit saturating counters. The second predictor is global: a 12-bit shift register of the most recent outcomes of all branches selects one of 4K 2-bit saturating counters. A chooser table of 4K 2-bit counters, also addressed by the global history, gives the final pick.

A fetch stage presents a PC on the lookup side and receives, in the same cycle, the final prediction, both component predictions, the chooser's pick and the global history used. When the branch resolves, the pipeline returns the PC, the real outcome, the captured global history and the two captured component predictions on the update side. The counters and histories are trained at the next clock edge. The chooser moves only when exactly one component was right: toward the global side when only the global prediction was correct, and toward the local side when only the local prediction was correct. Target addresses are not handled here.

There is no state machine. The only state is the set of tables and the global history register, written by a single update path.

Top module: `tourney_predictor`

## Requirements
- R1: While reset is held, and after release until the first update, every local history entry and the global history are zero. The 3-bit counters hold 011, the 2-bit global counters hold 01 and the chooser counters hold 01. Lookup therefore returns lk_taken=0, lk_local_pred=0, lk_global_pred=0, lk_use_global=0 and lk_ghist=0.
- R2: The local history entry is selected by lk_pc[11:2]. Its 10-bit value selects one of 1K 3-bit counters. lk_local_pred is the MSB of that counter.
- R3: lk_global_pred is the MSB of the 2-bit global counter selected by the current 12-bit global history.
- R4: lk_use_global is the MSB of the chooser counter selected by the current global history. lk_taken equals lk_global_pred when lk_use_global is 1, and lk_local_pred when it is 0.
- R5: On an update, let local-correct mean upd_local_pred==upd_taken and global-correct mean upd_global_pred==upd_taken. The chooser counter at upd_ghist increments, saturating at 3, when only global is correct. It decrements, saturating at 0, when only local is correct. It is unchanged when both are correct or both are wrong.
- R6: Each update with upd_valid=1 shifts upd_taken into bit 0 of the global history and drops bit 11. With upd_valid=0 the history keeps its value. lk_ghist shows the history.
- R7: Each update shifts upd_taken into bit 0 of the local history entry selected by upd_pc[11:2]. The 3-bit counter selected by that entry's old value steps toward the outcome: up when taken, down when not taken.
- R8: The 3-bit counters saturate at 0 and 7. The 2-bit counters saturate at 0 and 3.
- R9: The global counter and the chooser counter that an update trains are the ones selected by upd_ghist, not by the current global history. The global counter steps up when the branch was taken and down when it was not.
- R10: Lookup and update operate together. A lookup in the same cycle as an update returns the state from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | 32 | PC of the branch being looked up |
| lk_taken | output | 1 | Final predicted direction (1 = taken) |
| lk_local_pred | output | 1 | Local component prediction |
| lk_global_pred | output | 1 | Global component prediction |
| lk_use_global | output | 1 | Chooser pick (1 = global component) |
| lk_ghist | output | 12 | Global history used for this lookup |
| upd_valid | input | 1 | Train with the resolved branch this cycle |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_ghist | input | 12 | Global history captured at lookup |
| upd_local_pred | input | 1 | Local prediction captured at lookup |
| upd_global_pred | input | 1 | Global prediction captured at lookup |

## Verification
A long run of same-direction outcomes on one PC drives the counters into both saturation limits. It separates correct clamping from wrap-around, and it also walks the local history to all ones and back to zero. Chooser sequences supply captured component predictions of every correct/wrong combination, so each of the three chooser actions is told apart from the other two. Updates that carry a global history different from the live one show whether training follows the captured index or the live index. Idle cycles and mixed random traffic over a small set of aliasing PCs, compared against a bench model, check that state holds without updates and that same-cycle lookups see the state from before the update.

// File: rtl/tp_pkg.sv
package tp_pkg;

    // Chooser training action derived from component correctness
    typedef enum logic [1:0] {
        CH_HOLD     = 2'd0,
        CH_TO_GLOB  = 2'd1,
        CH_TO_LOCAL = 2'd2
    } ch_act_e;

endpackage

// File: rtl/tp_sat_table.sv
module tp_sat_table #(
    parameter int unsigned IDX_W = 12,
    parameter int unsigned CTR_W = 2,
    parameter int unsigned INIT  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CTR_W-1:0] rd_val,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_up
);

    localparam int unsigned N = 1 << IDX_W;
    localparam logic [CTR_W-1:0] MAXV   = '1;
    localparam logic [CTR_W-1:0] INIT_V = CTR_W'(INIT);

    logic [CTR_W-1:0] tbl_q [N];
    logic [CTR_W-1:0] cur;
    logic [CTR_W-1:0] nxt;

    assign rd_val = tbl_q[rd_idx];
    assign cur    = tbl_q[wr_idx];

    always_comb begin
        if (wr_up) begin
            nxt = (cur == MAXV) ? cur : cur + 1'b1;
        end else begin
            nxt = (cur == '0) ? cur : cur - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                tbl_q[i] <= INIT_V;
            end
        end else if (wr_en) begin
            tbl_q[wr_idx] <= nxt;
        end
    end

    // R8
    sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_up && cur == MAXV) |=> (tbl_q[$past(wr_idx)] == MAXV));

    // R8
    sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_up && cur == '0) |=> (tbl_q[$past(wr_idx)] == '0));

    // R5
    no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (tbl_q[$past(rd_idx)] == $past(rd_val)));

endmodule

// File: rtl/tp_local_comp.sv
module tp_local_comp #(
    parameter int unsigned PC_W     = 32,
    parameter int unsigned PC_LSB   = 2,
    parameter int unsigned LH_IDX_W = 10,
    parameter int unsigned LH_W     = 10,
    parameter int unsigned LC_W     = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LH_IDX_W-1:0] lk_idx,
    output logic               lk_pred,
    input  logic               upd_valid,
    input  logic [LH_IDX_W-1:0] upd_idx,
    input  logic               upd_taken
);

    localparam int unsigned LH_N    = 1 << LH_IDX_W;
    localparam int unsigned LC_INIT = (1 << (LC_W - 1)) - 1;

    logic [LH_W-1:0] lh_q [LH_N];
    logic [LH_W-1:0] lk_hist;
    logic [LH_W-1:0] u_hist;
    logic [LC_W-1:0] lk_ctr;

    assign lk_hist = lh_q[lk_idx];
    assign u_hist  = lh_q[upd_idx];
    assign lk_pred = lk_ctr[LC_W-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LH_N; i++) begin
                lh_q[i] <= '0;
            end
        end else if (upd_valid) begin
            lh_q[upd_idx] <= {u_hist[LH_W-2:0], upd_taken};
        end
    end

    tp_sat_table #(
        .IDX_W (LH_W),
        .CTR_W (LC_W),
        .INIT  (LC_INIT)
    ) u_lctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (lk_hist),
        .rd_val (lk_ctr),
        .wr_en  (upd_valid),
        .wr_idx (u_hist),
        .wr_up  (upd_taken)
    );

    // R7
    lhist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (lh_q[$past(upd_idx)][0] == $past(upd_taken)) &&
                      (lh_q[$past(upd_idx)][LH_W-1:1] == $past(u_hist[LH_W-2:0])));

endmodule

// File: rtl/tourney_predictor.sv
module tourney_predictor #(
    parameter int unsigned PC_W     = 32,
    parameter int unsigned PC_LSB   = 2,
    parameter int unsigned LH_IDX_W = 10,
    parameter int unsigned LH_W     = 10,
    parameter int unsigned LC_W     = 3,
    parameter int unsigned GH_W     = 12,
    parameter int unsigned GC_W     = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    output logic            lk_local_pred,
    output logic            lk_global_pred,
    output logic            lk_use_global,
    output logic [GH_W-1:0] lk_ghist,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [GH_W-1:0] upd_ghist,
    input  logic            upd_local_pred,
    input  logic            upd_global_pred
);

    import tp_pkg::*;

    localparam int unsigned GC_INIT = (1 << (GC_W - 1)) - 1;
    localparam int unsigned CH_INIT = 1;
    localparam int unsigned IDX_HI  = PC_LSB + LH_IDX_W;

    logic [GH_W-1:0]     ghist_q;
    logic [GC_W-1:0]     gctr_rd;
    logic [GC_W-1:0]     chsel_rd;
    logic [LH_IDX_W-1:0] lk_idx;
    logic [LH_IDX_W-1:0] up_idx;
    ch_act_e             ch_act;
    logic                ch_wr_en;
    logic                ch_wr_up;
    logic                local_ok;
    logic                global_ok;
    logic                unused_pc_bits;

    assign lk_idx = lk_pc[PC_LSB +: LH_IDX_W];
    assign up_idx = upd_pc[PC_LSB +: LH_IDX_W];
    assign unused_pc_bits = ^{lk_pc[PC_W-1:IDX_HI], lk_pc[PC_LSB-1:0],
                              upd_pc[PC_W-1:IDX_HI], upd_pc[PC_LSB-1:0]};

    // Global history register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ghist_q <= '0;
        end else if (upd_valid) begin
            ghist_q <= {ghist_q[GH_W-2:0], upd_taken};
        end
    end

    tp_local_comp #(
        .PC_W     (PC_W),
        .PC_LSB   (PC_LSB),
        .LH_IDX_W (LH_IDX_W),
        .LH_W     (LH_W),
        .LC_W     (LC_W)
    ) u_local (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_idx    (lk_idx),
        .lk_pred   (lk_local_pred),
        .upd_valid (upd_valid),
        .upd_idx   (up_idx),
        .upd_taken (upd_taken)
    );

    tp_sat_table #(
        .IDX_W (GH_W),
        .CTR_W (GC_W),
        .INIT  (GC_INIT)
    ) u_gctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (ghist_q),
        .rd_val (gctr_rd),
        .wr_en  (upd_valid),
        .wr_idx (upd_ghist),
        .wr_up  (upd_taken)
    );

    // Chooser training decision
    assign local_ok  = (upd_local_pred == upd_taken);
    assign global_ok = (upd_global_pred == upd_taken);

    always_comb begin
        if (global_ok && !local_ok) begin
            ch_act = CH_TO_GLOB;
        end else if (local_ok && !global_ok) begin
            ch_act = CH_TO_LOCAL;
        end else begin
            ch_act = CH_HOLD;
        end
    end

    always_comb begin
        ch_wr_en = 1'b0;
        ch_wr_up = 1'b0;
        unique case (ch_act)
            CH_TO_GLOB: begin
                ch_wr_en = upd_valid;
                ch_wr_up = 1'b1;
            end
            CH_TO_LOCAL: begin
                ch_wr_en = upd_valid;
                ch_wr_up = 1'b0;
            end
            default: begin
                ch_wr_en = 1'b0;
                ch_wr_up = 1'b0;
            end
        endcase
    end

    tp_sat_table #(
        .IDX_W (GH_W),
        .CTR_W (GC_W),
        .INIT  (CH_INIT)
    ) u_chooser (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (ghist_q),
        .rd_val (chsel_rd),
        .wr_en  (ch_wr_en),
        .wr_idx (upd_ghist),
        .wr_up  (ch_wr_up)
    );

    // Outputs
    assign lk_global_pred = gctr_rd[GC_W-1];
    assign lk_use_global  = chsel_rd[GC_W-1];
    assign lk_taken       = lk_use_global ? lk_global_pred : lk_local_pred;
    assign lk_ghist       = ghist_q;

    // R6
    ghist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (lk_ghist[0] == $past(upd_taken)) &&
                      (lk_ghist[GH_W-1:1] == $past(lk_ghist[GH_W-2:0])));

    // R6
    ghist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(lk_ghist));

    // R5
    chooser_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && (upd_local_pred == upd_global_pred)) |-> !ch_wr_en);

endmodule

// File: tb/tourney_predictor_tb.sv
`timescale 1ns/1ps
module tourney_predictor_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        lk_taken, lk_local_pred, lk_global_pred, lk_use_global;
    logic [11:0] lk_ghist;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [11:0] upd_ghist = '0;
    logic        upd_local_pred = 1'b0;
    logic        upd_global_pred = 1'b0;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tourney_predictor u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .lk_pc           (lk_pc),
        .lk_taken        (lk_taken),
        .lk_local_pred   (lk_local_pred),
        .lk_global_pred  (lk_global_pred),
        .lk_use_global   (lk_use_global),
        .lk_ghist        (lk_ghist),
        .upd_valid       (upd_valid),
        .upd_pc          (upd_pc),
        .upd_taken       (upd_taken),
        .upd_ghist       (upd_ghist),
        .upd_local_pred  (upd_local_pred),
        .upd_global_pred (upd_global_pred)
    );

    // Reference state
    logic [9:0]  m_lh [1024];
    logic [2:0]  m_lc [1024];
    logic [1:0]  m_gc [4096];
    logic [1:0]  m_ch [4096];
    logic [11:0] m_gh;

    function automatic logic [2:0] sat3(logic [2:0] v, logic up);
        if (up) return (v == 3'd7) ? v : v + 3'd1;
        return (v == 3'd0) ? v : v - 3'd1;
    endfunction

    function automatic logic [1:0] sat2(logic [1:0] v, logic up);
        if (up) return (v == 2'd3) ? v : v + 2'd1;
        return (v == 2'd0) ? v : v - 2'd1;
    endfunction

    function automatic logic exp_local(logic [31:0] pc);
        return m_lc[m_lh[pc[11:2]]][2];
    endfunction

    function automatic logic exp_global();
        return m_gc[m_gh][1];
    endfunction

    function automatic logic exp_use();
        return m_ch[m_gh][1];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 1024; i++) begin
            m_lh[i] = '0;
            m_lc[i] = 3'b011;
        end
        for (int i = 0; i < 4096; i++) begin
            m_gc[i] = 2'b01;
            m_ch[i] = 2'b01;
        end
        m_gh = '0;
    endtask

    task automatic model_upd(logic [31:0] pc, logic t, logic [11:0] gh,
                             logic lp, logic gp);
        logic [9:0] h;
        h = m_lh[pc[11:2]];
        m_lc[h] = sat3(m_lc[h], t);
        m_lh[pc[11:2]] = {h[8:0], t};
        m_gc[gh] = sat2(m_gc[gh], t);
        if ((gp == t) && (lp != t)) m_ch[gh] = sat2(m_ch[gh], 1'b1);
        else if ((lp == t) && (gp != t)) m_ch[gh] = sat2(m_ch[gh], 1'b0);
        m_gh = {m_gh[10:0], t};
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check lookup, update model after edge
    task automatic step(string tag, logic [31:0] pc, logic uv, logic [31:0] upc,
                        logic ut, logic [11:0] gh, logic lp, logic gp);
        logic el, eg, eu;
        @(negedge clk);
        lk_pc = pc;
        upd_valid = uv;
        upd_pc = upc;
        upd_taken = ut;
        upd_ghist = gh;
        upd_local_pred = lp;
        upd_global_pred = gp;
        #1;
        el = exp_local(pc);
        eg = exp_global();
        eu = exp_use();
        chk({tag, " R2 local"}, 32'(lk_local_pred), 32'(el));
        chk({tag, " R3 global"}, 32'(lk_global_pred), 32'(eg));
        chk({tag, " R5 chooser"}, 32'(lk_use_global), 32'(eu));
        chk({tag, " R4 final"}, 32'(lk_taken), 32'(eu ? eg : el));
        chk({tag, " R6 ghist"}, 32'(lk_ghist), 32'(m_gh));
        @(posedge clk);
        #1;
        if (uv) model_upd(upc, ut, gh, lp, gp);
    endtask

    // Update with captured values that match the model's lookup
    task automatic train(string tag, logic [31:0] pc, logic t);
        step(tag, pc, 1'b1, pc, t, m_gh, exp_local(pc), exp_global());
    endtask

    initial begin
        int unsigned seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset taken", 32'(lk_taken), 32'd0);
        chk("R1 reset local", 32'(lk_local_pred), 32'd0);
        chk("R1 reset global", 32'(lk_global_pred), 32'd0);
        chk("R1 reset use", 32'(lk_use_global), 32'd0);
        chk("R1 reset ghist", 32'(lk_ghist), 32'd0);

        // Saturation and local history walk on one PC
        for (int i = 0; i < 20; i++) train("R8 R7 up", 32'h0000_0100, 1'b1);
        for (int i = 0; i < 20; i++) train("R8 R7 down", 32'h0000_0100, 1'b0);

        // Stale global history index for training
        for (int i = 0; i < 6; i++)
            step("R9 stale up", 32'h40, 1'b1, 32'h40, 1'b1, 12'h0A5, 1'b0, 1'b0);
        for (int i = 0; i < 6; i++)
            step("R9 stale down", 32'h40, 1'b1, 32'h40, 1'b0, 12'h0A5, 1'b1, 1'b1);

        // Chooser: each correctness combination
        for (int i = 0; i < 5; i++)
            step("R5 to global", 32'h80, 1'b1, 32'h80, 1'b0, 12'h000, 1'b1, 1'b0);
        for (int i = 0; i < 2; i++)
            step("R5 hold both ok", 32'h80, 1'b1, 32'h80, 1'b1, 12'h000, 1'b1, 1'b1);
        for (int i = 0; i < 2; i++)
            step("R5 hold both bad", 32'h80, 1'b1, 32'h80, 1'b1, 12'h000, 1'b0, 1'b0);
        for (int i = 0; i < 12; i++) train("R5 clear ghist", 32'h84, 1'b0);
        step("R5 probe", 32'h84, 1'b0, 32'h0, 1'b0, 12'h0, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++)
            step("R5 to local", 32'h80, 1'b1, 32'h80, 1'b1, 12'h000, 1'b1, 1'b0);
        for (int i = 0; i < 12; i++) train("R5 clear again", 32'h84, 1'b0);

        // Idle cycles keep state
        for (int i = 0; i < 8; i++)
            step("R6 idle", 32'(i) << 2, 1'b0, 32'h100, 1'b1, 12'hFFF, 1'b1, 1'b1);

        // Mixed random traffic over aliasing PCs
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] pc;
            logic [4:0]  k;
            logic        uv, t, lp, gp;
            logic [11:0] gh;
            k  = 5'($urandom % 24);
            pc = ($urandom & 32'hFFFF_F000) | (32'(k) << 2);
            uv = ($urandom % 5) != 0;
            case (k % 3)
                0: t = 1'b1;
                1: t = (i % 4) != 0;
                default: t = 1'($urandom);
            endcase
            gh = (($urandom % 4) == 0) ? 12'($urandom) : m_gh;
            if (($urandom % 4) == 0) begin
                lp = 1'($urandom);
                gp = 1'($urandom);
            end else begin
                lp = exp_local(pc);
                gp = exp_global();
            end
            step("R10 random", pc, uv, pc, t, gh, lp, gp);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule